// File: doc/BRIEF.md
# Miss-Stream Prefetch Detector

This block sits beside a cache and watches the stream of misses that the cache reports, one per cycle at most. Each miss is tagged as coming from the instruction side or the data side. An instruction miss produces two outgoing requests in the following cycle. One is a demand fetch of the missed 64-byte block into the cache. The other is a prefetch of the next sequential block, routed to a separate stream buffer.

On the data side the block learns streams. When two data misses in a row land in the same 4 KB page, in different blocks less than 256 bytes apart, that page becomes a tracked stream. The stream takes an upward or downward direction from the order of the two misses. From then on, every data miss into a tracked page prefetches the adjacent block in that direction, until the walk would leave the page, at which point the stream is retired. At most eight streams are held, each on a different page. When a ninth page qualifies, it replaces the stream that was set up least recently.

Prefetch requests leave through a valid/ready port. The detector never stalls the miss stream. A request that has not been accepted stays on the port until a newer request overwrites it, and the older one is then lost.

Top module: `spd_prefetch_detect`

## Requirements
- R1: After reset, `dem_valid` and `pf_valid` are low and no page is tracked.
- R2: A miss with `miss_instr`=1 raises `dem_valid` one cycle later, with `dem_addr` equal to the miss address with its low 6 bits cleared. In the same cycle it presents a prefetch of `dem_addr`+64 with `pf_to_sbuf`=1. `dem_valid` is high in no other case.
- R3: A data miss whose page (address bits 31:12) equals that of the immediately preceding data miss, and whose block (bits 11:6) differs from it by 1, 2 or 3, triggers a stream. One cycle later it presents a prefetch of the adjacent block in the direction of travel, with `pf_to_sbuf`=0. A block gap of 0, a gap of 4 or more (256 bytes or more), or a different page triggers nothing.
- R4: A trigger whose second miss has the lower block number makes a downward stream, and its prefetch address is one block below the miss.
- R5: A data miss anywhere in a tracked page prefetches the block next to that miss in the stream's stored direction, with no new trigger needed.
- R6: When the prefetch target would fall outside the missed page (upward from block 63, downward from block 0), nothing is issued and the stream is retired. A later miss to that page alone then prefetches nothing.
- R7: At most eight streams exist, on distinct pages. A trigger with all eight busy replaces the stream whose trigger is oldest, and the other streams keep working.
- R8: A presented prefetch with `pf_ready` low stays unchanged on the port until accepted or overwritten by a newer request. With `pf_ready` high and no newer request, it is withdrawn after one cycle.
- R9: Instruction misses do not break the pairing of consecutive data misses used for triggering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A cache miss is reported this cycle |
| miss_instr | input | 1 | 1: instruction-side miss, 0: data-side miss |
| miss_addr | input | 32 | Byte address of the miss |
| dem_valid | output | 1 | Demand fetch of a missed instruction block |
| dem_addr | output | 32 | Block-aligned demand address |
| pf_valid | output | 1 | Prefetch request presented |
| pf_ready | input | 1 | Memory side accepts the prefetch |
| pf_addr | output | 32 | Block-aligned prefetch address |
| pf_to_sbuf | output | 1 | 1: fill the stream buffer, 0: fill the data cache |

## Verification
Replacement is the hardest case to reach from the ports. The bench must first get eight pages tracked at once, and that takes two adjacent misses per page plus one stream already retired at a page edge to leave a hole. A ninth trigger must then fall on a page whose age order is known. The directed sequence builds exactly that state, then probes the evicted page and a survivor with a miss from an unrelated page in between, so that the probe cannot form a fresh trigger. A following random phase keeps block offsets near the page edges and toggles `pf_ready`, and a behavioural model is compared on every clock throughout.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} spd_dir_e;
endpackage

// File: rtl/spd_match.sv
// Page lookup across the stream table plus lowest free slot search.
module spd_match #(
  parameter int STREAMS = 8,
  parameter int PN_W    = 20,
  parameter int IDX_W   = 3
) (
  input  logic [STREAMS-1:0]           ent_v,
  input  logic [STREAMS-1:0][PN_W-1:0] ent_pn,
  input  logic [PN_W-1:0]              look_pn,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx,
  output logic                         any_free,
  output logic [IDX_W-1:0]             free_idx
);
  logic [STREAMS-1:0] eq;

  generate
    for (genvar g = 0; g < STREAMS; g++) begin : g_cmp
      assign eq[g] = ent_v[g] && (ent_pn[g] == look_pn);
    end
  endgenerate

  always_comb begin
    hit      = |eq;
    any_free = ~&ent_v;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = STREAMS - 1; i >= 0; i--) begin
      if (eq[i])     hit_idx  = IDX_W'(i);
      if (!ent_v[i]) free_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/spd_age.sv
// Trigger-order ranking: rank 0 is the newest trigger, STREAMS-1 the oldest.
module spd_age #(
  parameter int STREAMS = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  logic [STREAMS-1:0][IDX_W-1:0] rank;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STREAMS; i++) rank[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < STREAMS; i++) begin
        if (IDX_W'(i) == touch_idx)          rank[i] <= '0;
        else if (rank[i] < rank[touch_idx])  rank[i] <= rank[i] + IDX_W'(1);
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < STREAMS; i++)
      if (rank[i] == IDX_W'(STREAMS - 1)) oldest_idx = IDX_W'(i);
  end
endmodule

// File: rtl/spd_prefetch_detect.sv
module spd_prefetch_detect
  import spd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_W      = 6,
  parameter int PAGE_W     = 12,
  parameter int NEAR_BYTES = 256,
  parameter int STREAMS    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic              miss_instr,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              dem_valid,
  output logic [ADDR_W-1:0] dem_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              pf_to_sbuf
);
  localparam int PN_W      = ADDR_W - PAGE_W;
  localparam int OFF_W     = PAGE_W - BLK_W;
  localparam int BN_W      = ADDR_W - BLK_W;
  localparam int IDX_W     = (STREAMS > 1) ? $clog2(STREAMS) : 1;
  localparam int NEAR_BLKS = NEAR_BYTES >> BLK_W;
  localparam logic [OFF_W:0] NEAR_LIM = (OFF_W + 1)'(NEAR_BLKS);

  // stream table
  logic [STREAMS-1:0]           ent_v;
  logic [STREAMS-1:0][PN_W-1:0] ent_pn;
  spd_dir_e                     ent_dir [STREAMS];

  // previous data miss
  logic             prev_v;
  logic [PN_W-1:0]  prev_pn;
  logic [OFF_W-1:0] prev_off;

  logic [PN_W-1:0]  m_pn;
  logic [OFF_W-1:0] m_off;
  logic [BN_W-1:0]  m_blk;
  logic             unused_lo;
  assign m_pn      = miss_addr[ADDR_W-1:PAGE_W];
  assign m_off     = miss_addr[PAGE_W-1:BLK_W];
  assign m_blk     = miss_addr[ADDR_W-1:BLK_W];
  assign unused_lo = ^miss_addr[BLK_W-1:0];

  logic             hit, any_free;
  logic [IDX_W-1:0] hit_idx, free_idx, oldest_idx, slot;

  spd_match #(.STREAMS(STREAMS), .PN_W(PN_W), .IDX_W(IDX_W)) u_match (
    .ent_v(ent_v), .ent_pn(ent_pn), .look_pn(m_pn),
    .hit(hit), .hit_idx(hit_idx), .any_free(any_free), .free_idx(free_idx)
  );

  logic is_data, same_pg, near, trig, upd, edge_ok, issue_d, alloc, new_pf;
  logic [OFF_W-1:0]  gap, nxt_off;
  spd_dir_e          step_dir;
  logic [ADDR_W-1:0] new_addr;

  spd_age #(.STREAMS(STREAMS), .IDX_W(IDX_W)) u_age (
    .clk(clk), .rst(rst), .touch(alloc), .touch_idx(slot), .oldest_idx(oldest_idx)
  );

  always_comb begin
    is_data  = miss_valid && !miss_instr;
    same_pg  = prev_v && (prev_pn == m_pn);
    gap      = (m_off >= prev_off) ? (m_off - prev_off) : (prev_off - m_off);
    near     = same_pg && (gap != '0) && ({1'b0, gap} < NEAR_LIM);
    step_dir = hit ? ent_dir[hit_idx] : ((m_off < prev_off) ? DIR_DOWN : DIR_UP);
    edge_ok  = (step_dir == DIR_DOWN) ? (m_off != '0) : (m_off != '1);
    nxt_off  = (step_dir == DIR_DOWN) ? (m_off - OFF_W'(1)) : (m_off + OFF_W'(1));
    upd      = is_data && hit;
    trig     = is_data && !hit && near;
    issue_d  = (upd || trig) && edge_ok;
    alloc    = trig && edge_ok;
    slot     = any_free ? free_idx : oldest_idx;
    new_pf   = miss_valid && (miss_instr || issue_d);
    new_addr = miss_instr ? {m_blk + BN_W'(1), {BLK_W{1'b0}}}
                          : {m_pn, nxt_off, {BLK_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v  <= '0;
      prev_v <= 1'b0;
    end else begin
      if (is_data) begin
        prev_v   <= 1'b1;
        prev_pn  <= m_pn;
        prev_off <= m_off;
      end
      if (upd && !edge_ok) ent_v[hit_idx] <= 1'b0;
      if (alloc) begin
        ent_v[slot]   <= 1'b1;
        ent_pn[slot]  <= m_pn;
        ent_dir[slot] <= step_dir;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dem_valid  <= 1'b0;
      dem_addr   <= '0;
      pf_valid   <= 1'b0;
      pf_addr    <= '0;
      pf_to_sbuf <= 1'b0;
    end else begin
      dem_valid <= miss_valid && miss_instr;
      dem_addr  <= {m_blk, {BLK_W{1'b0}}};
      if (new_pf) begin
        pf_valid   <= 1'b1;
        pf_addr    <= new_addr;
        pf_to_sbuf <= miss_instr;
      end else if (pf_ready) begin
        pf_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spd_chk.sv
module spd_chk #(
  parameter int ADDR_W  = 32,
  parameter int BLK_W   = 6,
  parameter int PN_W    = 20,
  parameter int STREAMS = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         miss_valid,
  input logic                         miss_instr,
  input logic [ADDR_W-1:0]            miss_addr,
  input logic                         dem_valid,
  input logic [ADDR_W-1:0]            dem_addr,
  input logic                         pf_valid,
  input logic                         pf_ready,
  input logic [ADDR_W-1:0]            pf_addr,
  input logic                         pf_to_sbuf,
  input logic [STREAMS-1:0]           ent_v,
  input logic [STREAMS-1:0][PN_W-1:0] ent_pn
);
  localparam logic [ADDR_W-1:0] LOW = ADDR_W'((1 << BLK_W) - 1);
  localparam logic [ADDR_W-1:0] BLK = ADDR_W'(1 << BLK_W);

  // R2
  instr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_instr) |=> (dem_valid && pf_valid && pf_to_sbuf &&
      dem_addr == ($past(miss_addr) & ~LOW) && pf_addr == dem_addr + BLK));

  // R2
  dem_only_instr_chk: assert property (@(posedge clk) disable iff (rst)
    !(miss_valid && miss_instr) |=> !dem_valid);

  // R8
  pf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready && !miss_valid) |=>
      (pf_valid && $stable(pf_addr) && $stable(pf_to_sbuf)));

  // R8
  pf_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready && !miss_valid) |=> !pf_valid);

  // R3
  pf_align_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> ((pf_addr & LOW) == '0));

  // R7
  generate
    for (genvar i = 0; i < STREAMS; i++) begin : g_a
      for (genvar j = i + 1; j < STREAMS; j++) begin : g_b
        distinct_pg_chk: assert property (@(posedge clk) disable iff (rst)
          !(ent_v[i] && ent_v[j] && ent_pn[i] == ent_pn[j]));
      end
    end
  endgenerate
endmodule

bind spd_prefetch_detect spd_chk #(
  .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PN_W(PN_W), .STREAMS(STREAMS)
) u_chk (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_instr(miss_instr),
  .miss_addr(miss_addr), .dem_valid(dem_valid), .dem_addr(dem_addr),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
  .pf_to_sbuf(pf_to_sbuf), .ent_v(ent_v), .ent_pn(ent_pn)
);

// File: tb/sim_spd_prefetch_detect.sv
module sim_spd_prefetch_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic miss_valid = 1'b0, miss_instr = 1'b0, pf_ready = 1'b1;
  logic [31:0] miss_addr = '0;
  logic dem_valid, pf_valid, pf_to_sbuf;
  logic [31:0] dem_addr, pf_addr;

  always #2 clk = ~clk;

  spd_prefetch_detect u0 (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_instr(miss_instr),
    .miss_addr(miss_addr), .dem_valid(dem_valid), .dem_addr(dem_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .pf_to_sbuf(pf_to_sbuf)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  bit          m_v [8];
  int unsigned m_pn [8];
  bit          m_dn [8];
  int          m_ts [8];
  int          tsc = 0;
  bit          mp_v = 0;
  int unsigned mp_pn = 0;
  int          mp_off = 0;
  bit          e_demv = 0, e_pfv = 0, e_sbuf = 0;
  logic [31:0] e_dema = '0, e_pfa = '0;

  always @(posedge clk) begin : model
    bit nw, sb, dn, ok;
    int h, s, off, g;
    int unsigned pn;
    logic [31:0] na;
    if (rst) begin
      foreach (m_v[i]) m_v[i] = 0;
      mp_v = 0; e_demv = 0; e_pfv = 0; e_sbuf = 0; e_pfa = '0; e_dema = '0;
    end else begin
      nw = 0; sb = 0; na = '0;
      e_demv = miss_valid && miss_instr;
      e_dema = miss_addr & 32'hFFFF_FFC0;
      if (miss_valid && miss_instr) begin
        nw = 1; sb = 1; na = e_dema + 32'd64;
      end else if (miss_valid) begin
        pn = miss_addr >> 12; off = int'((miss_addr >> 6) & 32'h3F);
        h = -1;
        for (int i = 0; i < 8; i++) if (m_v[i] && m_pn[i] == pn) h = i;
        if (h >= 0) begin
          dn = m_dn[h]; ok = dn ? (off > 0) : (off < 63);
          if (ok) begin nw = 1; na = (pn << 12) | 32'((dn ? off - 1 : off + 1) << 6); end
          else m_v[h] = 0;
        end else if (mp_v && mp_pn == pn) begin
          g = (off > mp_off) ? off - mp_off : mp_off - off;
          if (g != 0 && g < 4) begin
            dn = off < mp_off; ok = dn ? (off > 0) : (off < 63);
            if (ok) begin
              s = -1;
              for (int i = 7; i >= 0; i--) if (!m_v[i]) s = i;
              if (s < 0) begin
                s = 0;
                for (int i = 1; i < 8; i++) if (m_ts[i] < m_ts[s]) s = i;
              end
              m_v[s] = 1; m_pn[s] = pn; m_dn[s] = dn; m_ts[s] = tsc; tsc++;
              nw = 1; na = (pn << 12) | 32'((dn ? off - 1 : off + 1) << 6);
            end
          end
        end
        mp_v = 1; mp_pn = pn; mp_off = off;
      end
      if (nw) begin e_pfv = 1; e_pfa = na; e_sbuf = sb; end
      else if (pf_ready) e_pfv = 0;
    end
  end

  // every-clock comparison against the model (R2 R3 R5 R8)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (dem_valid !== e_demv || (e_demv && dem_addr !== e_dema) ||
          pf_valid !== e_pfv || (e_pfv && (pf_addr !== e_pfa || pf_to_sbuf !== e_sbuf))) begin
        errors++;
        $display("FAIL model R2 R3 R5 R8: act dem=%b/%h pf=%b/%h/%b exp dem=%b/%h pf=%b/%h/%b",
                 dem_valid, dem_addr, pf_valid, pf_addr, pf_to_sbuf,
                 e_demv, e_dema, e_pfv, e_pfa, e_sbuf);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic send(input bit ins, input logic [31:0] a);
    miss_valid = 1'b1; miss_instr = ins; miss_addr = a;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic pf_is(input string tag, input logic [31:0] a, input bit sb);
    chk({tag, " valid"}, 32'(pf_valid), 32'd1);
    chk({tag, " addr"}, pf_addr, a);
    chk({tag, " dest"}, 32'(pf_to_sbuf), 32'(sb));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pf_valid", 32'(pf_valid), 32'd0);
    chk("R1 dem_valid", 32'(dem_valid), 32'd0);

    send(1, 32'h1234_5678);
    chk("R2 dem_valid", 32'(dem_valid), 32'd1);
    chk("R2 dem_addr", dem_addr, 32'h1234_5640);
    pf_is("R2", 32'h1234_5680, 1);

    send(0, 32'h0000_1100);
    send(1, 32'h0000_9000);
    send(0, 32'h0000_1140);
    pf_is("R3 R9 up trigger", 32'h0000_1180, 0);

    send(0, 32'h0000_1800);
    pf_is("R5 tracked page", 32'h0000_1840, 0);

    send(0, 32'h0000_2400);
    send(0, 32'h0000_2380);
    pf_is("R4 down trigger", 32'h0000_2340, 0);

    send(0, 32'h0000_3000);
    send(0, 32'h0000_3100);
    chk("R3 gap 256 no trigger", 32'(pf_valid), 32'd0);
    send(0, 32'h0000_3100);
    chk("R3 same block no trigger", 32'(pf_valid), 32'd0);
    send(0, 32'h0000_4FC0);
    send(0, 32'h0000_5000);
    chk("R3 other page no trigger", 32'(pf_valid), 32'd0);
    send(0, 32'h0000_3100);
    send(0, 32'h0000_3140);
    pf_is("R3 gap 1", 32'h0000_3180, 0);

    send(0, 32'h0000_1FC0);
    chk("R6 edge no prefetch", 32'(pf_valid), 32'd0);
    send(0, 32'h0000_7000);
    send(0, 32'h0000_1800);
    chk("R6 retired page", 32'(pf_valid), 32'd0);

    for (int p = 16; p < 23; p++) begin
      send(0, 32'(p << 12) | 32'h400);
      send(0, 32'(p << 12) | 32'h440);
      pf_is("R7 fill", 32'(p << 12) | 32'h480, 0);
    end
    send(0, 32'h0000_7000);
    send(0, 32'h0000_2800);
    chk("R7 oldest evicted", 32'(pf_valid), 32'd0);
    send(0, 32'h0000_3800);
    pf_is("R7 survivor", 32'h0000_3840, 0);

    pf_ready = 1'b0;
    send(1, 32'h0000_A000);
    repeat (3) @(negedge clk);
    pf_is("R8 held", 32'h0000_A040, 1);
    send(1, 32'h0000_B000);
    pf_is("R8 overwritten", 32'h0000_B040, 1);
    pf_ready = 1'b1;
    @(negedge clk);
    chk("R8 withdrawn", 32'(pf_valid), 32'd0);

    for (int k = 0; k < 600; k++) begin
      int unsigned pg, off;
      pg  = 32 + ($urandom % 10);
      off = ($urandom % 2) ? ($urandom % 8) : (56 + $urandom % 8);
      miss_valid = ($urandom % 3) != 0;
      miss_instr = ($urandom % 5) == 0;
      miss_addr  = 32'((pg << 12) | (off << 6) | ($urandom % 64));
      pf_ready   = ($urandom % 4) != 0;
      @(negedge clk);
    end
    miss_valid = 1'b0;
    pf_ready = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule